// File: doc/BRIEF.md
# Maskable Completion-Event Interrupt Controller

This block raises a message-signalled interrupt when a queued completion finishes with its interrupt flag set. On such a completion it sets a sticky completion-status flag and arms a pending message. The message is a one-cycle request that carries a software-programmed data word and address word. The request is sent once the mask bit is clear and the downstream ready input is high. While the message is blocked, the pending bit stays visible to software.

Software reaches the block through a flat register port. Writes take effect on the clock edge, and reads are combinational. The port exposes four registers:

- a control register at A0h, with the mask in bit 31 and the read-only pending bit in bit 30;
- a status register at 9Ch, whose bit 0 is the write-1-to-clear completion flag;
- the message data word at A4h;
- the message address word at A8h.

A configuration input disables the queued-completion feature. While it is low, the control register reads as zero and the event logic is idle.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the control register reads 8000_0000h (mask bit 31 set, pending bit 30 clear), status bit 0 reads 0, the data and address registers read 0, and msg_valid is low.
- R2: A completion with cmp_iflag high while status bit 0 is clear sets status bit 0 and control bit 30 at the next edge. A completion with cmp_iflag low changes neither.
- R3: A flagged completion that arrives while status bit 0 is already set does not re-arm control bit 30.
- R4: While control bit 31 is 1, msg_valid never rises.
- R5: msg_valid is high in the same cycle that bit 30 is set, bit 31 is clear, msg_ready is high and qi_supported is high. Bit 30 clears at the next edge, so each pending episode produces exactly one message.
- R6: Bit 30 stays set for as long as the message is held back, whether by the mask or by msg_ready being low.
- R7: Writing a word with bit 0 = 1 to 9Ch clears status bit 0 and control bit 30 without sending a message. Writing a word with bit 0 = 0 changes neither.
- R8: A status clear in the same cycle as a new flagged completion leaves status bit 0 set and arms control bit 30 as a new condition.
- R9: Only bit 31 of the control register is writable. Writes to bit 30 and to bits 29:0 have no effect, and bits 29:0 read as 0.
- R10: With qi_supported low, the control register reads 0, control writes are ignored, and completions arm nothing.
- R11: The data word (A4h) and address word (A8h) are read/write. They appear on msg_data and msg_addr while msg_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qi_supported | input | 1 | Queued completion feature present |
| cmp_done | input | 1 | Completion event strobe |
| cmp_iflag | input | 1 | Completion requests an interrupt |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_ready | input | 1 | Downstream can accept a message |
| msg_valid | output | 1 | Message request, one cycle |
| msg_data | output | 32 | Message data word |
| msg_addr | output | 32 | Message address word |

## Verification
msg_valid is combinational on the registered pending and mask state and on msg_ready. The bench therefore samples it in the same cycle it drives ready, shortly after driving inputs and before the rising edge. Every register effect (status, pending, mask, data words) appears one edge after its stimulus. Those values are read back through the combinational read port one nanosecond after that edge, with the write and event strobes already deasserted. Each table row thus checks its message output in the cycle of the stimulus and its register state in the cycle after.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_STAT = 8'h9C;
    localparam logic [REG_AW-1:0] OFF_CTRL = 8'hA0;
    localparam logic [REG_AW-1:0] OFF_DATA = 8'hA4;
    localparam logic [REG_AW-1:0] OFF_ADDR = 8'hA8;

    localparam int unsigned MASK_BIT = 31;
    localparam int unsigned PEND_BIT = 30;

    // mask resets set, pending and status reset clear
    typedef struct packed {
        logic mask;
        logic pend;
        logic stat;
    } core_st_t;

    localparam core_st_t CORE_RST = '{mask: 1'b1, pend: 1'b0, stat: 1'b0};

endpackage

// File: rtl/evt_irq_core.sv
module evt_irq_core
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qi_en,
    input  logic mask_we,
    input  logic mask_wval,
    input  logic stat_w1c,
    input  logic cmp_done,
    input  logic cmp_iflag,
    input  logic msg_ready,
    output logic mask,
    output logic pend,
    output logic stat,
    output logic fire
);

    core_st_t st_d, st_q;
    logic     new_cond;

    always_comb begin
        st_d     = st_q;
        new_cond = qi_en & cmp_done & cmp_iflag & (~st_q.stat | stat_w1c);
        fire     = qi_en & st_q.pend & ~st_q.mask & msg_ready;

        if (mask_we) begin
            st_d.mask = mask_wval;
        end

        st_d.stat = new_cond | (st_q.stat & ~stat_w1c);

        if (new_cond) begin
            st_d.pend = 1'b1;
        end else if (stat_w1c || fire) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
    assign pend = st_q.pend;
    assign stat = st_q.stat;

endmodule

// File: rtl/evt_irq_msgregs.sv
module evt_irq_msgregs
    import evt_irq_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 2,
    parameter logic [NREG*REG_AW-1:0] OFFS = {OFF_ADDR, OFF_DATA}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [NREG*DW-1:0] vals
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_d, val_q;
        logic          hit;

        always_comb begin
            hit   = wr_en && (addr == OFFS[g*REG_AW +: REG_AW]);
            val_d = hit ? wdata : val_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign vals[g*DW +: DW] = val_q;
    end

endmodule

// File: rtl/evt_irq_rdmux.sv
module evt_irq_rdmux
    import evt_irq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [REG_AW-1:0] addr,
    input  logic              qi_en,
    input  logic              mask,
    input  logic              pend,
    input  logic              stat,
    input  logic [DW-1:0]     data_val,
    input  logic [DW-1:0]     addr_val,
    output logic [31:0]       rdata
);

    logic [31:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[MASK_BIT] = mask;
        ctrl_word[PEND_BIT] = pend;
        if (!qi_en) begin
            ctrl_word = '0;
        end

        unique case (addr)
            OFF_CTRL: rdata = ctrl_word;
            OFF_STAT: rdata = {31'b0, stat};
            OFF_DATA: rdata = 32'(data_val);
            OFF_ADDR: rdata = 32'(addr_val);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qi_supported,
    input  logic              cmp_done,
    input  logic              cmp_iflag,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [DW-1:0]     msg_data,
    output logic [DW-1:0]     msg_addr
);

    localparam int unsigned NMSG = 2;

    logic              mask_w, pend_w, stat_w, fire_w;
    logic              ctrl_we_w, stat_w1c_w;
    logic [NMSG*DW-1:0] msg_vals_w;

    always_comb begin
        ctrl_we_w  = qi_supported && reg_wr_en && (reg_addr == OFF_CTRL);
        stat_w1c_w = qi_supported && reg_wr_en && (reg_addr == OFF_STAT) && reg_wdata[0];
    end

    evt_irq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .qi_en     (qi_supported),
        .mask_we   (ctrl_we_w),
        .mask_wval (reg_wdata[MASK_BIT]),
        .stat_w1c  (stat_w1c_w),
        .cmp_done  (cmp_done),
        .cmp_iflag (cmp_iflag),
        .msg_ready (msg_ready),
        .mask      (mask_w),
        .pend      (pend_w),
        .stat      (stat_w),
        .fire      (fire_w)
    );

    evt_irq_msgregs #(
        .DW   (DW),
        .NREG (NMSG),
        .OFFS ({OFF_ADDR, OFF_DATA})
    ) u_msgregs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata[DW-1:0]),
        .vals  (msg_vals_w)
    );

    evt_irq_rdmux #(
        .DW (DW)
    ) u_rdmux (
        .addr     (reg_addr),
        .qi_en    (qi_supported),
        .mask     (mask_w),
        .pend     (pend_w),
        .stat     (stat_w),
        .data_val (msg_vals_w[0 +: DW]),
        .addr_val (msg_vals_w[DW +: DW]),
        .rdata    (reg_rdata)
    );

    assign msg_valid = fire_w;
    assign msg_data  = msg_vals_w[0 +: DW];
    assign msg_addr  = msg_vals_w[DW +: DW];

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic qi_supported,
    input logic cmp_done,
    input logic cmp_iflag,
    input logic msg_ready,
    input logic msg_valid,
    input logic mask,
    input logic pend,
    input logic stat,
    input logic stat_w1c
);

    assert_valid_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (pend && msg_ready && qi_supported));

    assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !msg_valid);

    assert_single_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !stat_w1c) |=> !pend);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !msg_valid && !stat_w1c) |=> pend);

    assert_no_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && stat && !stat_w1c) |=> !pend);

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && !(cmp_done && cmp_iflag)) |=> (!stat && !pend));

    assert_coincide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && cmp_done && cmp_iflag) |=> (stat && pend));

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat && cmp_done && cmp_iflag && qi_supported) |=> (stat && pend));

    assert_pend_implies_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> stat);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .qi_supported (qi_supported),
    .cmp_done     (cmp_done),
    .cmp_iflag    (cmp_iflag),
    .msg_ready    (msg_ready),
    .msg_valid    (msg_valid),
    .mask         (mask_w),
    .pend         (pend_w),
    .stat         (stat_w),
    .stat_w1c     (stat_w1c_w)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qi_supported = 1'b1;
    logic        cmp_done = 1'b0;
    logic        cmp_iflag = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_ready = 1'b0;
    logic        msg_valid;
    logic [31:0] msg_data;
    logic [31:0] msg_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .qi_supported(qi_supported),
        .cmp_done(cmp_done), .cmp_iflag(cmp_iflag),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_data(msg_data), .msg_addr(msg_addr)
    );

    typedef struct packed {
        logic        evt;
        logic        ifl;
        logic        rdy;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        exp_valid;
        logic [31:0] exp_ctrl;
        logic        exp_stat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{0,0,0,1,8'hA4,32'h1234_5678,0,32'h8000_0000,0,8'd11}, // R11 data word
        '{0,0,0,1,8'hA8,32'hFEE0_1000,0,32'h8000_0000,0,8'd11}, // R11 address word
        '{1,0,1,0,8'h00,32'h0,        0,32'h8000_0000,0,8'd2},  // R2 unflagged
        '{1,1,1,0,8'h00,32'h0,        0,32'hC000_0000,1,8'd2},  // R2 arm
        '{0,0,1,0,8'h00,32'h0,        0,32'hC000_0000,1,8'd4},  // R4 masked
        '{1,1,1,0,8'h00,32'h0,        0,32'hC000_0000,1,8'd3},  // R3 no re-arm
        '{0,0,0,1,8'hA0,32'h0,        0,32'h4000_0000,1,8'd6},  // R6 unmask, stalled
        '{0,0,0,0,8'h00,32'h0,        0,32'h4000_0000,1,8'd6},  // R6 still stalled
        '{0,0,1,0,8'h00,32'h0,        1,32'h0000_0000,1,8'd5},  // R5 send
        '{0,0,1,0,8'h00,32'h0,        0,32'h0000_0000,1,8'd5},  // R5 one only
        '{1,1,0,0,8'h00,32'h0,        0,32'h0000_0000,1,8'd3},  // R3 stat set
        '{0,0,0,1,8'h9C,32'h1,        0,32'h0000_0000,0,8'd7},  // R7 clear
        '{1,1,0,0,8'h00,32'h0,        0,32'h4000_0000,1,8'd2},  // R2 arm again
        '{0,0,0,1,8'h9C,32'h1,        0,32'h0000_0000,0,8'd7},  // R7 clear pending
        '{0,0,1,0,8'h00,32'h0,        0,32'h0000_0000,0,8'd7},  // R7 no message
        '{1,1,0,0,8'h00,32'h0,        0,32'h4000_0000,1,8'd2},  // R2 arm
        '{0,0,1,0,8'h00,32'h0,        1,32'h0000_0000,1,8'd5},  // R5 send
        '{1,1,0,1,8'h9C,32'h1,        0,32'h4000_0000,1,8'd8},  // R8 coincident
        '{0,0,0,1,8'hA0,32'hFFFF_FFFF,0,32'hC000_0000,1,8'd9},  // R9 only mask
        '{0,0,1,1,8'hA0,32'h0,        0,32'h4000_0000,1,8'd4},  // R4 mask still set
        '{0,0,1,0,8'h00,32'h0,        1,32'h0000_0000,1,8'd5},  // R5 send
        '{0,0,0,1,8'h9C,32'hFFFF_FFFE,0,32'h0000_0000,1,8'd7}   // R7 bit0 zero
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic idle_inputs();
        cmp_done = 0; cmp_iflag = 0; reg_wr_en = 0; msg_ready = 0;
    endtask

    task automatic wr_cycle(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state, checked while still in reset
        rd(8'hA0, d); chk("R1 ctrl", d, 32'h8000_0000);
        rd(8'h9C, d); chk("R1 stat", d, 32'h0);
        rd(8'hA4, d); chk("R1 data", d, 32'h0);
        rd(8'hA8, d); chk("R1 addr", d, 32'h0);
        chk("R1 valid", {31'b0, msg_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmp_done = VEC[i].evt; cmp_iflag = VEC[i].ifl; msg_ready = VEC[i].rdy;
            reg_wr_en = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].wdata;
            #0.5;
            chk($sformatf("R%0d vec%0d valid", VEC[i].req, i), {31'b0, msg_valid},
                {31'b0, VEC[i].exp_valid});
            if (VEC[i].exp_valid) begin
                chk("R11 msg_data", msg_data, 32'h1234_5678);
                chk("R11 msg_addr", msg_addr, 32'hFEE0_1000);
            end
            @(posedge clk);
            #1;
            idle_inputs();
            rd(8'hA0, d);
            chk($sformatf("R%0d vec%0d ctrl", VEC[i].req, i), d, VEC[i].exp_ctrl);
            rd(8'h9C, d);
            chk($sformatf("R%0d vec%0d stat", VEC[i].req, i), d, {31'b0, VEC[i].exp_stat});
        end

        // R11 readback of message words
        rd(8'hA4, d); chk("R11 data readback", d, 32'h1234_5678);
        rd(8'hA8, d); chk("R11 addr readback", d, 32'hFEE0_1000);

        // R10 feature disabled: mask is 0, status is 1 here
        wr_cycle(8'h9C, 32'h1);
        @(negedge clk);
        qi_supported = 0;
        #0.2;
        rd(8'hA0, d); chk("R10 ctrl reads zero", d, 32'h0);
        wr_cycle(8'hA0, 32'h8000_0000);
        @(negedge clk);
        cmp_done = 1; cmp_iflag = 1;
        @(posedge clk);
        #1;
        idle_inputs();
        rd(8'h9C, d); chk("R10 no status", d, 32'h0);
        @(negedge clk);
        qi_supported = 1;
        #0.2;
        rd(8'hA0, d); chk("R10 write ignored", d, 32'h0);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 0;
        #0.5;
        rd(8'hA0, d); chk("R1 ctrl after reset", d, 32'h8000_0000);
        rd(8'hA4, d); chk("R1 data after reset", d, 32'h0);
        @(negedge clk);
        rst_n = 1;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule